// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes the write cycles sent to a parallel NOR flash that follows the common two-cycle command protocol. A host writes a command byte in one bus cycle. Some commands need a second cycle that carries data or a confirm code. The block tracks the active command and whether a second cycle is pending, keeps a status byte, and applies program and sector-erase operations to an internal byte array built from registers.

Reads are registered. Each read returns one of four sources, chosen by the active command: array data, the status byte, a two-entry identifier, or a small query table. Array reads and program data use 1, 2 or 4 consecutive byte addresses. The byte order within the bus word is fixed by a parameter. When a status, identifier or query byte is returned on a wide access, it is repeated in each device-wide lane. A write-protect input turns program and erase attempts into error flags and leaves the array unchanged.

Top module: `nce_flash_cmd`

## Requirements
- R1: After reset the block is in array mode with no second cycle pending and status 0x00. Every array byte reads 0xFF, and a status read returns 0x00.
- R2: The read data register updates on the clock edge where `bus_rd` is high and `bus_wr` is low. In array mode, size code 0/1/2 returns 1/2/4 bytes from `bus_addr` upward, wrapping at the top of the array. With `BIG_ENDIAN`=0 the lowest address lands in bits [7:0]. With `BIG_ENDIAN`=1 the lowest address lands in the most significant byte of the access width. Bits above the access width read 0.
- R3: A first-cycle byte of 0x10 or 0x40 arms a program. The next write stores its data with the same byte placement as R2 and sets status bit 7.
- R4: A first-cycle byte of 0x20 followed by 0xD0 sets every byte of one sector to 0xFF and sets status bit 7. The sector holds 2^SECTOR_W bytes, and its base is the confirm-cycle address with its low SECTOR_W bits cleared.
- R5: After 0x20, a second cycle of 0xFF, or of any value other than 0xD0, returns the block to array mode and leaves the array unchanged.
- R6: While `wr_protect` is high, a program second cycle sets status bits 4 and 7, and an erase confirm sets status bits 5 and 7. Neither one changes the array. Status bits stay set until they are cleared.
- R7: In the program, erase, clear-status, lock and status-read (0x70) states, a read returns the status byte. It appears in the low byte of each DEV_BYTES-wide lane within the access width, and all other bits are 0.
- R8: A first-cycle byte of 0x50 sets status to 0x00, and later reads return status.
- R9: A first-cycle byte of 0x60 followed by 0xD0 or 0x01 sets status bit 7, and reads then return status. Following 0x60 with 0xFF or any other value returns the block to array mode.
- R10: After 0x90, reads return an identifier byte, filled across lanes as in R7. The index is `bus_addr` shifted right by log2(DEV_BYTES). Index 0 gives MFR_ID, index 1 gives PART_ID, and every other index gives 0x00.
- R11: After 0x98, reads return a query byte, filled across lanes as in R7. Index 0x10/0x11/0x12 gives 0x51/0x52/0x59, 0x13 gives 0x01, 0x27 gives ADDR_W, 0x28 gives 0x02, 0x2C gives 0x01, and 0x2D/0x2E give the low/high byte of (sector count - 1). Every other index gives 0x00.
- R12: A first-cycle byte of 0xFF, 0xF0 or any unlisted value puts the block in array mode with no second cycle pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wr | input | 1 | Write strobe, one cycle per bus write |
| bus_wdata | input | 8*BANK_BYTES | Write data; the command byte is in bits [7:0] |
| bus_rd | input | 1 | Read strobe |
| wr_protect | input | 1 | High makes program and erase fail with error flags |
| bus_rdata | output | 8*BANK_BYTES | Registered read data |

## Verification
The embedded properties check the following on every cycle:
- a second-cycle flag is only ever pending in the program, erase or lock states;
- a program second cycle, and any erase confirm, always sets the ready bit;
- a protected erase always sets the erase-error bit;
- 0xF0 always leaves the block idle in array mode;
- an erased sector reads 0xFF;
- status-class reads always carry the current status in the low lane.

Some behaviour only the bench scenarios can show:
- byte ordering across both endian variants on every address and size;
- wrap-around at the top of the array;
- exact sector bounds;
- abandoned sequences leaving data untouched;
- identifier and query values.

// File: rtl/nce_pkg.sv
package nce_pkg;

   typedef enum logic [2:0] {
      M_ARRAY, M_PROG, M_ERASE, M_CLRST, M_LOCK, M_STATUS, M_IDENT, M_QUERY
   } nce_mode_e;

   localparam logic [7:0] OP_PROG_A  = 8'h10;
   localparam logic [7:0] OP_PROG_B  = 8'h40;
   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_CLRST   = 8'h50;
   localparam logic [7:0] OP_LOCK    = 8'h60;
   localparam logic [7:0] OP_LOCKALT = 8'h01;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_ARRAY   = 8'hFF;

   localparam int ST_READY = 7;
   localparam int ST_ERERR = 5;
   localparam int ST_PGERR = 4;

   // number of bytes touched by a size code, limited to the bank width
   function automatic int unsigned nce_span(input logic [1:0] code, input int unsigned bank);
      int unsigned n;
      n = 32'd1 << code;
      return (n > bank) ? bank : n;
   endfunction

   function automatic logic nce_reports_status(input nce_mode_e m);
      return (m == M_PROG) || (m == M_ERASE) || (m == M_CLRST) ||
             (m == M_LOCK) || (m == M_STATUS);
   endfunction

   function automatic logic [7:0] nce_query_byte(input logic [7:0] idx,
                                                 input logic [7:0] size_log2,
                                                 input logic [15:0] blk_m1);
      case (idx)
         8'h10:   return 8'h51;
         8'h11:   return 8'h52;
         8'h12:   return 8'h59;
         8'h13:   return 8'h01;
         8'h27:   return size_log2;
         8'h28:   return 8'h02;
         8'h2C:   return 8'h01;
         8'h2D:   return blk_m1[7:0];
         8'h2E:   return blk_m1[15:8];
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/nce_seq.sv
module nce_seq
   import nce_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [7:0] wbyte_i,
   input  logic       protect_i,
   output nce_mode_e  mode_o,
   output logic [7:0] status_o,
   output logic       prog_we_o,
   output logic       erase_go_o
);

   nce_mode_e  mode_q;
   logic       phase_q;
   logic [7:0] status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= M_ARRAY;
         phase_q  <= 1'b0;
         status_q <= 8'h00;
      end else if (wr_i) begin
         if (!phase_q) begin
            case (wbyte_i)
               OP_PROG_A, OP_PROG_B: begin mode_q <= M_PROG;  phase_q <= 1'b1; end
               OP_ERASE:             begin mode_q <= M_ERASE; phase_q <= 1'b1; end
               OP_LOCK:              begin mode_q <= M_LOCK;  phase_q <= 1'b1; end
               OP_CLRST:             begin mode_q <= M_CLRST; status_q <= 8'h00; end
               OP_STATUS:            mode_q <= M_STATUS;
               OP_IDENT:             mode_q <= M_IDENT;
               OP_QUERY:             mode_q <= M_QUERY;
               default:              mode_q <= M_ARRAY;
            endcase
         end else begin
            phase_q <= 1'b0;
            case (mode_q)
               M_PROG: begin
                  status_q[ST_READY] <= 1'b1;
                  if (protect_i) status_q[ST_PGERR] <= 1'b1;
               end
               M_ERASE: begin
                  if (wbyte_i == OP_CONFIRM) begin
                     status_q[ST_READY] <= 1'b1;
                     if (protect_i) status_q[ST_ERERR] <= 1'b1;
                  end else begin
                     mode_q <= M_ARRAY;
                  end
               end
               M_LOCK: begin
                  if (wbyte_i == OP_CONFIRM || wbyte_i == OP_LOCKALT)
                     status_q[ST_READY] <= 1'b1;
                  else
                     mode_q <= M_ARRAY;
               end
               default: mode_q <= M_ARRAY;
            endcase
         end
      end
   end

   assign mode_o     = mode_q;
   assign status_o   = status_q;
   assign prog_we_o  = wr_i && phase_q && (mode_q == M_PROG) && !protect_i;
   assign erase_go_o = wr_i && phase_q && (mode_q == M_ERASE) &&
                       (wbyte_i == OP_CONFIRM) && !protect_i;

   a_r9_phase_modes: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q |-> (mode_q == M_PROG || mode_q == M_ERASE || mode_q == M_LOCK));

   a_r3_prog_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && phase_q && mode_q == M_PROG) |=> status_q[ST_READY]);

   a_r4_erase_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && phase_q && mode_q == M_ERASE && wbyte_i == OP_CONFIRM) |=> status_q[ST_READY]);

   a_r6_erase_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && phase_q && mode_q == M_ERASE && wbyte_i == OP_CONFIRM && protect_i)
      |=> status_q[ST_ERERR]);

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !phase_q && wbyte_i == OP_CLRST) |=> (status_q == 8'h00));

   a_r12_idle_op: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !phase_q && wbyte_i == 8'hF0) |=> (mode_q == M_ARRAY && !phase_q));

endmodule

// File: rtl/nce_swizzle.sv
// Maps between address-ordered bytes and bus-word byte lanes; the mapping is
// its own inverse, so one instance serves the write path and one the read path.
module nce_swizzle #(
   parameter int BANK_BYTES = 4,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [1:0]                  size_i,
   input  logic [BANK_BYTES-1:0][7:0]  in_b,
   output logic [BANK_BYTES-1:0][7:0]  out_b
);
   import nce_pkg::*;

   localparam int LW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;

   if (BIG_ENDIAN) begin : g_be
      always_comb begin
         int n;
         n = int'(nce_span(size_i, BANK_BYTES));
         for (int j = 0; j < BANK_BYTES; j++) begin
            out_b[j] = (j < n) ? in_b[LW'(n - 1 - j)] : 8'h00;
         end
      end
   end else begin : g_le
      always_comb begin
         int n;
         n = int'(nce_span(size_i, BANK_BYTES));
         for (int j = 0; j < BANK_BYTES; j++) begin
            out_b[j] = (j < n) ? in_b[j] : 8'h00;
         end
      end
   end

endmodule

// File: rtl/nce_array.sv
module nce_array #(
   parameter int ADDR_W     = 8,
   parameter int SECTOR_W   = 4,
   parameter int BANK_BYTES = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we_i,
   input  logic                        erase_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [1:0]                  size_i,
   input  logic [BANK_BYTES-1:0][7:0]  wseq_i,
   output logic [BANK_BYTES-1:0][7:0]  rseq_o
);
   import nce_pkg::*;

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int SECTOR = 1 << SECTOR_W;

   logic [7:0]        mem [DEPTH];
   logic [ADDR_W-1:0] base;

   assign base = {addr_i[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (erase_i) begin
         for (int i = 0; i < SECTOR; i++) mem[base | ADDR_W'(i)] <= 8'hFF;
      end else if (we_i) begin
         for (int k = 0; k < BANK_BYTES; k++) begin
            if (k < int'(nce_span(size_i, BANK_BYTES)))
               mem[ADDR_W'(addr_i + ADDR_W'(k))] <= wseq_i[k];
         end
      end
   end

   always_comb begin
      for (int k = 0; k < BANK_BYTES; k++) rseq_o[k] = mem[ADDR_W'(addr_i + ADDR_W'(k))];
   end

   a_r4_sector_low: assert property (@(posedge clk) disable iff (!rst_n)
      erase_i |=> (mem[$past(base)] == 8'hFF));

   a_r4_sector_high: assert property (@(posedge clk) disable iff (!rst_n)
      erase_i |=> (mem[$past(base) | ADDR_W'(SECTOR - 1)] == 8'hFF));

endmodule

// File: rtl/nce_rdsel.sv
module nce_rdsel
   import nce_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          SECTOR_W   = 4,
   parameter int          BANK_BYTES = 4,
   parameter int          DEV_BYTES  = 1,
   parameter logic [7:0]  MFR_ID     = 8'h89,
   parameter logic [7:0]  PART_ID    = 8'h18
) (
   input  nce_mode_e                   mode_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [1:0]                  size_i,
   input  logic [7:0]                  status_i,
   input  logic [BANK_BYTES-1:0][7:0]  arr_word_i,
   output logic [BANK_BYTES-1:0][7:0]  word_o
);

   localparam int          LANE_SH = $clog2(DEV_BYTES);
   localparam logic [15:0] BLK_M1  = 16'((1 << (ADDR_W - SECTOR_W)) - 1);
   localparam logic [7:0]  SZ_LOG2 = 8'(ADDR_W);

   logic [7:0] idx;
   logic [7:0] pick;

   always_comb begin
      int n;
      n   = int'(nce_span(size_i, BANK_BYTES));
      idx = 8'(addr_i >> LANE_SH);
      case (mode_i)
         M_IDENT: pick = (idx == 8'd0) ? MFR_ID : ((idx == 8'd1) ? PART_ID : 8'h00);
         M_QUERY: pick = nce_query_byte(idx, SZ_LOG2, BLK_M1);
         default: pick = status_i;
      endcase
      if (mode_i == M_ARRAY) begin
         word_o = arr_word_i;
      end else begin
         for (int j = 0; j < BANK_BYTES; j++)
            word_o[j] = (j < n && (j % DEV_BYTES) == 0) ? pick : 8'h00;
      end
   end

endmodule

// File: rtl/nce_flash_cmd.sv
module nce_flash_cmd
   import nce_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          SECTOR_W   = 4,
   parameter int          BANK_BYTES = 4,
   parameter int          DEV_BYTES  = 1,
   parameter bit          BIG_ENDIAN = 1'b0,
   parameter logic [7:0]  MFR_ID     = 8'h89,
   parameter logic [7:0]  PART_ID    = 8'h18,
   localparam int         DATA_W     = 8 * BANK_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic              wr_protect,
   output logic [DATA_W-1:0] bus_rdata
);

   if (!(BANK_BYTES == 1 || BANK_BYTES == 2 || BANK_BYTES == 4)) begin : g_bad_bank
      $error("BANK_BYTES must be 1, 2 or 4");
   end
   if (DEV_BYTES < 1 || DEV_BYTES > BANK_BYTES || (DEV_BYTES & (DEV_BYTES - 1)) != 0) begin : g_bad_dev
      $error("DEV_BYTES must be a power of two no wider than BANK_BYTES");
   end
   if (SECTOR_W < 1 || SECTOR_W >= ADDR_W || ADDR_W > 16) begin : g_bad_geom
      $error("need 1 <= SECTOR_W < ADDR_W <= 16");
   end

   nce_mode_e                   mode;
   logic [7:0]                  status;
   logic                        prog_we;
   logic                        erase_go;
   logic [BANK_BYTES-1:0][7:0]  wseq;
   logic [BANK_BYTES-1:0][7:0]  rseq;
   logic [BANK_BYTES-1:0][7:0]  arr_word;
   logic [BANK_BYTES-1:0][7:0]  next_word;

   nce_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr),
      .wbyte_i    (bus_wdata[7:0]),
      .protect_i  (wr_protect),
      .mode_o     (mode),
      .status_o   (status),
      .prog_we_o  (prog_we),
      .erase_go_o (erase_go)
   );

   nce_swizzle #(.BANK_BYTES(BANK_BYTES), .BIG_ENDIAN(BIG_ENDIAN)) u_wswz (
      .size_i (bus_size),
      .in_b   (bus_wdata),
      .out_b  (wseq)
   );

   nce_array #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BANK_BYTES(BANK_BYTES)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (prog_we),
      .erase_i (erase_go),
      .addr_i  (bus_addr),
      .size_i  (bus_size),
      .wseq_i  (wseq),
      .rseq_o  (rseq)
   );

   nce_swizzle #(.BANK_BYTES(BANK_BYTES), .BIG_ENDIAN(BIG_ENDIAN)) u_rswz (
      .size_i (bus_size),
      .in_b   (rseq),
      .out_b  (arr_word)
   );

   nce_rdsel #(
      .ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BANK_BYTES(BANK_BYTES),
      .DEV_BYTES(DEV_BYTES), .MFR_ID(MFR_ID), .PART_ID(PART_ID)
   ) u_rdsel (
      .mode_i     (mode),
      .addr_i     (bus_addr),
      .size_i     (bus_size),
      .status_i   (status),
      .arr_word_i (arr_word),
      .word_o     (next_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bus_rdata <= '0;
      else if (bus_rd && !bus_wr) bus_rdata <= next_word;
   end

   a_r7_status_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && nce_reports_status(mode)) |=> (bus_rdata[7:0] == $past(status)));

   if (BANK_BYTES > 1) begin : g_upper_chk
      a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !bus_wr && bus_size == 2'd0) |=> (bus_rdata[DATA_W-1:8] == '0));
   end

endmodule

// File: tb/nce_flash_cmd_test.sv
`timescale 1ns/1ps
module nce_flash_cmd_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        wr_protect = 1'b0;
   logic [31:0] rdata_le, rdata_be;

   always #5 clk = ~clk;

   nce_flash_cmd #(.BIG_ENDIAN(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .wr_protect(wr_protect), .bus_rdata(rdata_le));

   nce_flash_cmd #(.BIG_ENDIAN(1'b1)) uut_be (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .wr_protect(wr_protect), .bus_rdata(rdata_be));

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [7:0]  m_le [256];
   logic [7:0]  m_be [256];
   logic [31:0] got_le, got_be;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic bwrite(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_size = s; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] a, input logic [7:0] b);
      bwrite(a, {24'h0, b}, 2'd0);
   endtask

   task automatic bread(input logic [7:0] a, input logic [1:0] s);
      @(negedge clk);
      bus_addr = a; bus_size = s; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      got_le = rdata_le;
      got_be = rdata_be;
   endtask

   function automatic logic [31:0] exp_word(input bit be, input logic [7:0] a, input logic [1:0] s);
      logic [31:0] w;
      int n;
      logic [7:0] b;
      n = 1 << s;
      w = '0;
      for (int k = 0; k < n; k++) begin
         b = be ? m_be[8'(a + k)] : m_le[8'(a + k)];
         if (be) w[8*(n-1-k) +: 8] = b;
         else    w[8*k +: 8] = b;
      end
      return w;
   endfunction

   function automatic logic [31:0] fill(input logic [7:0] b, input logic [1:0] s);
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < (1 << s); k++) w[8*k +: 8] = b;
      return w;
   endfunction

   task automatic both(input string req, input logic [31:0] e_le, input logic [31:0] e_be);
      chk({req, " le"}, got_le, e_le);
      chk({req, " be"}, got_be, e_be);
   endtask

   initial begin
      #(10 * 150000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin m_le[i] = 8'hFF; m_be[i] = 8'hFF; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      bread(8'h00, 2'd2); both("R1 erased read", 32'hFFFFFFFF, 32'hFFFFFFFF);
      bread(8'hFD, 2'd1); both("R1 erased read", 32'h0000FFFF, 32'h0000FFFF);
      cmd(8'h00, 8'h70);
      bread(8'h00, 2'd2); both("R1 status zero", 32'h0, 32'h0);

      // R3: byte program sweep over the whole array, R7 status after each
      for (int a = 0; a < 256; a++) begin
         logic [7:0] v;
         v = 8'((a * 7 + 3) ^ 8'h5A);
         cmd(8'(a), (a % 2 == 0) ? 8'h40 : 8'h10);
         bwrite(8'(a), {24'hEEEEEE, v}, 2'd0);
         m_le[a] = v; m_be[a] = v;
         bread(8'(a), 2'd0); both("R3 R7 ready status", 32'h80, 32'h80);
      end
      bread(8'h11, 2'd2); both("R7 status lanes", 32'h80808080, 32'h80808080);

      // R2: read sweep, every address and size
      cmd(8'h00, 8'hFF);
      for (int a = 0; a < 256; a++) begin
         for (int s = 0; s < 3; s++) begin
            bread(8'(a), 2'(s));
            both("R2 array read", exp_word(1'b0, 8'(a), 2'(s)), exp_word(1'b1, 8'(a), 2'(s)));
         end
      end

      // R3 / R2: four-byte program wrapping at the top
      cmd(8'hFE, 8'h10);
      bwrite(8'hFE, 32'hA1B2C3D4, 2'd2);
      for (int k = 0; k < 4; k++) begin
         m_le[8'(8'hFE + k)] = 8'(32'hA1B2C3D4 >> (8 * k));
         m_be[8'(8'hFE + k)] = 8'(32'hA1B2C3D4 >> (8 * (3 - k)));
      end
      cmd(8'h00, 8'hFF);
      bread(8'hFE, 2'd2); both("R3 wide program", 32'hA1B2C3D4, 32'hA1B2C3D4);
      bread(8'hFE, 2'd0); both("R2 byte order", 32'hD4, 32'hA1);
      bread(8'h00, 2'd1); both("R2 wrap", exp_word(1'b0, 8'h00, 2'd1), exp_word(1'b1, 8'h00, 2'd1));

      // R4: sector erase of 0x30..0x3F via confirm at 0x37
      cmd(8'h37, 8'h20);
      cmd(8'h37, 8'hD0);
      for (int i = 8'h30; i < 8'h40; i++) begin m_le[i] = 8'hFF; m_be[i] = 8'hFF; end
      bread(8'h00, 2'd0); both("R4 R7 erase ready", 32'h80, 32'h80);
      cmd(8'h00, 8'hFF);
      for (int a = 8'h2E; a < 8'h42; a++) begin
         bread(8'(a), 2'd0);
         both("R4 sector bounds", exp_word(1'b0, 8'(a), 2'd0), exp_word(1'b1, 8'(a), 2'd0));
      end

      // R5: abandoned erase
      cmd(8'h50, 8'h20);
      cmd(8'h50, 8'hFF);
      bread(8'h50, 2'd0); both("R5 abandon FF", {24'h0, m_le[8'h50]}, {24'h0, m_be[8'h50]});
      cmd(8'h52, 8'h20);
      cmd(8'h52, 8'h33);
      bread(8'h50, 2'd2); both("R5 abandon other", exp_word(1'b0, 8'h50, 2'd2), exp_word(1'b1, 8'h50, 2'd2));

      // R8: clear status
      cmd(8'h00, 8'h50);
      bread(8'h00, 2'd2); both("R8 cleared", 32'h0, 32'h0);

      // R6: write protect
      wr_protect = 1'b1;
      cmd(8'h05, 8'h40);
      bwrite(8'h05, 32'h00, 2'd0);
      bread(8'h05, 2'd0); both("R6 program error", 32'h90, 32'h90);
      cmd(8'h64, 8'h20);
      cmd(8'h64, 8'hD0);
      bread(8'h64, 2'd0); both("R6 erase error sticky", 32'hB0, 32'hB0);
      wr_protect = 1'b0;
      cmd(8'h00, 8'hFF);
      bread(8'h05, 2'd0); both("R6 data kept", {24'h0, m_le[8'h05]}, {24'h0, m_be[8'h05]});
      bread(8'h60, 2'd2); both("R6 sector kept", exp_word(1'b0, 8'h60, 2'd2), exp_word(1'b1, 8'h60, 2'd2));
      cmd(8'h00, 8'h50);
      bread(8'h00, 2'd1); both("R8 R7 clear state reads status", 32'h0, 32'h0);

      // R9: lock sequences
      cmd(8'h00, 8'h60); cmd(8'h00, 8'hD0);
      bread(8'h00, 2'd0); both("R9 lock D0", 32'h80, 32'h80);
      cmd(8'h00, 8'h50);
      cmd(8'h00, 8'h60); cmd(8'h00, 8'h01);
      bread(8'h00, 2'd1); both("R9 lock 01", 32'h8080, 32'h8080);
      cmd(8'h00, 8'h60); cmd(8'h00, 8'hFF);
      bread(8'h20, 2'd0); both("R9 lock exit", {24'h0, m_le[8'h20]}, {24'h0, m_be[8'h20]});
      cmd(8'h00, 8'h60); cmd(8'h00, 8'h22);
      bread(8'h21, 2'd0); both("R9 lock unknown", {24'h0, m_le[8'h21]}, {24'h0, m_be[8'h21]});

      // R10: identifier
      cmd(8'h00, 8'h90);
      bread(8'h00, 2'd0); both("R10 mfr", 32'h89, 32'h89);
      bread(8'h01, 2'd0); both("R10 part", 32'h18, 32'h18);
      bread(8'h02, 2'd0); both("R10 other", 32'h00, 32'h00);
      bread(8'h01, 2'd2); both("R10 lanes", 32'h18181818, 32'h18181818);

      // R11: query table, swept across all low indices
      cmd(8'h00, 8'h98);
      for (int i = 0; i < 64; i++) begin
         logic [7:0] e;
         case (i)
            8'h10: e = 8'h51; 8'h11: e = 8'h52; 8'h12: e = 8'h59; 8'h13: e = 8'h01;
            8'h27: e = 8'd8;  8'h28: e = 8'h02; 8'h2C: e = 8'h01; 8'h2D: e = 8'h0F;
            default: e = 8'h00;
         endcase
         bread(8'(i), 2'd0); both("R11 query", {24'h0, e}, {24'h0, e});
      end
      bread(8'h10, 2'd2); both("R11 lanes", 32'h51515151, 32'h51515151);

      // R12: idle and unknown opcodes
      cmd(8'h00, 8'h70);
      cmd(8'h00, 8'hF0);
      bread(8'h40, 2'd0); both("R12 F0", {24'h0, m_le[8'h40]}, {24'h0, m_be[8'h40]});
      cmd(8'h00, 8'h90);
      cmd(8'h00, 8'h3C);
      bread(8'h41, 2'd1); both("R12 unknown", exp_word(1'b0, 8'h41, 2'd1), exp_word(1'b1, 8'h41, 2'd1));
      cmd(8'h00, 8'h98);
      cmd(8'h00, 8'hFF);
      bread(8'h10, 2'd0); both("R12 FF", {24'h0, m_le[8'h10]}, {24'h0, m_be[8'h10]});

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule